// File: doc/BRIEF.md
# MSI Request Vector Generator

This block sits on the endpoint side of a PCIe bridge and converts a device-side interrupt strobe into one Message Signaled Interrupt send request. It acts only on a rising edge of the request input. In that same cycle it captures the requested vector number and reduces it to the number of vectors the host enabled. It then builds the message data word and hands it to a downstream memory-write packet engine through a valid/ready handshake.

The controller has two named states. In `ST_IDLE` it waits for an accepted edge. The transition `T_CAPTURE` (accepted edge) moves it to `ST_PEND`. In `ST_PEND` the captured request stays on the send port until ready is seen, and the transition `T_HANDOFF` (ready high) moves it back to `ST_IDLE`. An accepted edge that arrives while in `ST_PEND` is not queued. It increments a saturating drop counter and sets a sticky overflow flag.

The block also reports two values. One is the capable vector count, a log2 parameter. The other is the enabled vector width, copied straight from the enable field of the host's Message Control register.

Top module: `msi_vec_gen`

## Requirements
- R1: A request is taken only on a rising edge of `irq_req_i`. Holding the input high after a request has been handed off produces no further request.
- R2: An edge is accepted only when `msi_en_i` is 1 and `is_rc_i` is 0. Otherwise it has no effect: no valid and no drop count.
- R3: `mmc_o` equals the log2 capable-count parameter (0..5, where code k means 2^k vectors). `vec_width_o` equals `msg_ctrl_i[6:4]`.
- R4: With enable code N in `msg_ctrl_i[6:4]` (0..5, meaning 2^N vectors), `send_vec_o` is the requested vector with every bit at position N or above cleared.
- R5: Enable codes 6 and 7 are reserved and are treated as 0, so vector 0 is sent.
- R6: `send_data_o` is `base_data_i` with its low N bits replaced by the masked vector.
- R7: While `send_valid_o` is 1 and `send_ready_i` is 0, valid stays 1 and both `send_vec_o` and `send_data_o` hold steady. Valid drops in the cycle after ready is seen.
- R8: The vector and data are latched at the clock edge where the rising edge is detected. Later changes on `vec_num_i` or `base_data_i` do not alter a pending message.
- R9: An accepted edge while a request is pending is dropped. It increments `drop_cnt_o`, which saturates at its maximum, and sets `overflow_o`, which stays 1 until reset.
- R10: A synchronous active-high `rst` clears the pending request, the edge history, `drop_cnt_o` and `overflow_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | 1 | Interrupt request strobe, edge sensitive |
| vec_num_i | input | VEC_W (5) | Requested vector number |
| msi_en_i | input | 1 | MSI enabled by the host |
| is_rc_i | input | 1 | Bridge configured as root complex |
| msg_ctrl_i | input | 16 | Host Message Control register |
| base_data_i | input | DATA_W (16) | Host-programmed message data |
| send_valid_o | output | 1 | Send request valid |
| send_ready_i | input | 1 | Packet engine accepts the request |
| send_vec_o | output | VEC_W (5) | Masked vector of the pending request |
| send_data_o | output | DATA_W (16) | Message data of the pending request |
| vec_width_o | output | 3 | Enabled vector width code |
| mmc_o | output | 3 | Capable vector count code |
| overflow_o | output | 1 | Sticky flag: a request was dropped |
| drop_cnt_o | output | DROP_W (4) | Saturating count of dropped requests |

## Verification
The main sweep walks every enable code 0..7 against every vector 0..31. Each vector is sent over a base data word with all bits set, so the check shows exactly which bits were replaced. It separates correct masking from over-masking and under-masking, and it separates reserved codes from valid ones. In each trial the vector input is scrambled right after capture, which shows whether the value was latched or is being passed through combinationally. Each trial also leaves the request held high after the handoff, which shows edge detection apart from level detection. Separate patterns cover a stalled ready with repeated edges, where drops must be counted and must saturate, and edges with MSI disabled or in root-complex mode, which must be ignored.

// File: rtl/msi_pkg.sv
package msi_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } msi_state_e;

    localparam int unsigned MSG_CTRL_W = 16;
    localparam int unsigned CODE_W     = 3;
    localparam int unsigned CODE_MAX   = 5;
endpackage

// File: rtl/msi_edge_det.sv
module msi_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic rise_o
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~lvl_q;

    // R1: a level that is high now and was high in the previous cycle gives no edge
    AST_NO_LEVEL_RETRIGGER: assert property (@(posedge clk) disable iff (rst)
        (lvl_i && $past(lvl_i)) |-> !rise_o); // R1
endmodule

// File: rtl/msi_vec_mask.sv
module msi_vec_mask
    import msi_pkg::*;
#(
    parameter int unsigned VEC_W  = 5,
    parameter int unsigned DATA_W = 16
) (
    input  logic [CODE_W-1:0] mme_i,
    input  logic [VEC_W-1:0]  vec_i,
    input  logic [DATA_W-1:0] base_i,
    output logic [VEC_W-1:0]  vec_o,
    output logic [DATA_W-1:0] data_o
);
    logic [CODE_W-1:0] n_eff;
    logic [DATA_W-1:0] keep;
    logic [DATA_W-1:0] vec_ext;

    // reserved codes (above CODE_MAX) fall back to a single vector
    assign n_eff = (mme_i > CODE_W'(CODE_MAX)) ? '0 : mme_i;

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            keep[i] = (i < int'(n_eff));
        end
        vec_ext = '0;
        for (int i = 0; i < VEC_W && i < DATA_W; i++) begin
            vec_ext[i] = vec_i[i];
        end
        vec_ext = vec_ext & keep;
        data_o  = (base_i & ~keep) | vec_ext;
        vec_o   = VEC_W'(vec_ext);
    end
endmodule

// File: rtl/msi_vec_gen.sv
module msi_vec_gen
    import msi_pkg::*;
#(
    parameter int unsigned VEC_W    = 5,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned CAP_LOG2 = 5,
    parameter int unsigned DROP_W   = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  irq_req_i,
    input  logic [VEC_W-1:0]      vec_num_i,
    input  logic                  msi_en_i,
    input  logic                  is_rc_i,
    input  logic [MSG_CTRL_W-1:0] msg_ctrl_i,
    input  logic [DATA_W-1:0]     base_data_i,
    output logic                  send_valid_o,
    input  logic                  send_ready_i,
    output logic [VEC_W-1:0]      send_vec_o,
    output logic [DATA_W-1:0]     send_data_o,
    output logic [CODE_W-1:0]     vec_width_o,
    output logic [CODE_W-1:0]     mmc_o,
    output logic                  overflow_o,
    output logic [DROP_W-1:0]     drop_cnt_o
);
    localparam logic [DROP_W-1:0] DROP_MAX = '1;

    msi_state_e st_q, st_d;
    logic rise, accept, capture, drop;
    logic [VEC_W-1:0]  vec_m, vec_q;
    logic [DATA_W-1:0] data_m, data_q;
    logic ovf_q;
    logic [DROP_W-1:0] drop_q;

    msi_edge_det u_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (irq_req_i),
        .rise_o (rise)
    );

    msi_vec_mask #(.VEC_W(VEC_W), .DATA_W(DATA_W)) u_mask (
        .mme_i  (msg_ctrl_i[6:4]),
        .vec_i  (vec_num_i),
        .base_i (base_data_i),
        .vec_o  (vec_m),
        .data_o (data_m)
    );

    assign accept = rise & msi_en_i & ~is_rc_i;

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // next state and strobes
    always_comb begin
        st_d    = st_q;
        capture = 1'b0;
        drop    = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (accept) begin          // T_CAPTURE
                    st_d    = ST_PEND;
                    capture = 1'b1;
                end
            end
            ST_PEND: begin
                drop = accept;
                if (send_ready_i) st_d = ST_IDLE;  // T_HANDOFF
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // payload and drop bookkeeping
    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q  <= '0;
            data_q <= '0;
            ovf_q  <= 1'b0;
            drop_q <= '0;
        end else begin
            if (capture) begin
                vec_q  <= vec_m;
                data_q <= data_m;
            end
            if (drop) begin
                ovf_q <= 1'b1;
                if (drop_q != DROP_MAX) drop_q <= drop_q + 1'b1;
            end
        end
    end

    assign send_valid_o = (st_q == ST_PEND);
    assign send_vec_o   = vec_q;
    assign send_data_o  = data_q;
    assign vec_width_o  = msg_ctrl_i[6:4];
    assign mmc_o        = CODE_W'(CAP_LOG2);
    assign overflow_o   = ovf_q;
    assign drop_cnt_o   = drop_q;

    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (rst)
        (send_valid_o && !send_ready_i) |=>
            (send_valid_o && $stable(send_vec_o) && $stable(send_data_o))); // R7
    AST_RELEASE_ON_READY: assert property (@(posedge clk) disable iff (rst)
        (send_valid_o && send_ready_i) |=> !send_valid_o); // R7
    AST_GATED_NO_SEND: assert property (@(posedge clk) disable iff (rst)
        (!send_valid_o && (is_rc_i || !msi_en_i)) |=> !send_valid_o); // R2
    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow_o |=> overflow_o); // R9
    AST_DROP_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (drop_cnt_o >= $past(drop_cnt_o))); // R9
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (capture && msg_ctrl_i[6:5] == 2'b11) |=> (send_vec_o == '0)); // R5
endmodule

// File: tb/sim_msi_vec_gen.sv
module sim_msi_vec_gen;
    localparam int CLK_PERIOD = 10;
    localparam int VEC_W  = 5;
    localparam int DATA_W = 16;
    localparam int DROP_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irq = 1'b0;
    logic [VEC_W-1:0] vec = '0;
    logic en = 1'b1;
    logic rc = 1'b0;
    logic [15:0] mctl = '0;
    logic [DATA_W-1:0] base = '1;
    logic ready = 1'b0;
    logic valid;
    logic [VEC_W-1:0] svec;
    logic [DATA_W-1:0] sdata;
    logic [2:0] vw, mmc;
    logic ovf;
    logic [DROP_W-1:0] dcnt;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_vec_gen #(.VEC_W(VEC_W), .DATA_W(DATA_W), .CAP_LOG2(5), .DROP_W(DROP_W)) u0 (
        .clk(clk), .rst(rst), .irq_req_i(irq), .vec_num_i(vec),
        .msi_en_i(en), .is_rc_i(rc), .msg_ctrl_i(mctl), .base_data_i(base),
        .send_valid_o(valid), .send_ready_i(ready), .send_vec_o(svec),
        .send_data_o(sdata), .vec_width_o(vw), .mmc_o(mmc),
        .overflow_o(ovf), .drop_cnt_o(dcnt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;
        // R10 reset state
        chk(valid == 0, "R10 valid", int'(valid), 0);
        chk(ovf == 0, "R10 overflow", int'(ovf), 0);
        chk(dcnt == 0, "R10 drop", int'(dcnt), 0);
        chk(mmc == 3'd5, "R3 mmc", int'(mmc), 5);

        // sweep: every enable code and every vector; R4 R5 R6 R8 R1 R3
        for (int code = 0; code < 8; code++) begin
            mctl = 16'(code) << 4;
            #1;
            chk(vw == 3'(code), "R3 width", int'(vw), code);
            for (int v = 0; v < 32; v++) begin
                int n, ev, ed;
                n  = (code > 5) ? 0 : code;
                ev = v & ((1 << n) - 1);
                ed = (16'hFFFF & ~((1 << n) - 1)) | ev;
                vec = 5'(v); irq = 1'b1;
                tick();
                vec = ~5'(v); base = 16'h0000;   // R8 scramble after capture
                #1;
                chk(valid == 1, "R1 valid on edge", int'(valid), 1);
                chk(int'(svec) == ev, (code > 5) ? "R5 vec" : "R4 vec", int'(svec), ev);
                chk(int'(sdata) == ed, "R6 R8 data", int'(sdata), ed);
                ready = 1'b1;
                tick();
                ready = 1'b0;
                tick();                          // irq still high
                chk(valid == 0, "R1 held level", int'(valid), 0);
                irq = 1'b0; base = '1;
                tick();
            end
        end
        mctl = 16'h0030;   // code 3

        // R7 stall and R9 drops
        vec = 5'd9; irq = 1'b1; tick(); irq = 1'b0; tick();
        for (int k = 0; k < 5; k++) begin
            chk(valid == 1 && svec == 5'd1, "R7 hold", int'(svec), 1);
            irq = 1'b1; vec = 5'(k); tick(); irq = 1'b0; tick();
        end
        chk(int'(dcnt) == 5, "R9 drop count", int'(dcnt), 5);
        chk(ovf == 1, "R9 overflow", int'(ovf), 1);
        for (int k = 0; k < 14; k++) begin
            irq = 1'b1; tick(); irq = 1'b0; tick();
        end
        chk(int'(dcnt) == 15, "R9 saturate", int'(dcnt), 15);
        ready = 1'b1; tick(); ready = 1'b0; #1;
        chk(valid == 0, "R7 release", int'(valid), 0);
        chk(ovf == 1, "R9 sticky", int'(ovf), 1);

        // R2 gating
        en = 1'b0; irq = 1'b1; tick(); irq = 1'b0; tick();
        chk(valid == 0, "R2 msi disabled", int'(valid), 0);
        en = 1'b1; rc = 1'b1; irq = 1'b1; tick(); irq = 1'b0; tick();
        chk(valid == 0, "R2 root complex", int'(valid), 0);
        rc = 1'b0; vec = 5'd6; irq = 1'b1; tick(); irq = 1'b0;
        chk(valid == 1 && svec == 5'd6, "R2 enabled", int'(svec), 6);

        // R10 reset clears pending and flags
        rst = 1'b1; tick(); rst = 1'b0; #1;
        chk(valid == 0, "R10 pending cleared", int'(valid), 0);
        chk(ovf == 0 && dcnt == 0, "R10 flags cleared", int'(dcnt), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule